// File: doc/BRIEF.md
# Scan Sleep and Wake Controller

This block governs the duty cycle of a touch-matrix scanner. Each time the scanner reports the end of a full pass over the keys, the controller decides whether to launch another pass at once or to put the scan logic to sleep. Any touch reported in the finished pass, or any host bus access seen since the last launch, keeps the scanner running. When neither is present, the scan logic sleeps. A sleep setting of zero keeps the scanner running continuously.

While asleep, an 8-bit down counter advances on ticks from a low-rate divider. When the programmed number of ticks has elapsed, the block wakes and launches a periodic scan. A host access during sleep wakes the block at once. Every wake, and every launch, is followed by one complete scan before the block may sleep again. The clock-enable output lets the surrounding logic stop the scan clock while the block sleeps. Gating the power and decoding the bus are left to neighbouring blocks.

Top module: `scan_sleep_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after its release, the block is in its launch state: `scanStart`=1, `asleep`=0, `scanClkEn`=1. On the next clock it moves to scanning (`scanStart`=0).
- R2: `scanStart` is a pulse exactly one cycle long. It is followed by the scanning state, in which `scanStart`=0, `asleep`=0 and `scanClkEn`=1.
- R3: A `scanDone` pulse received while scanning, with `anyTouch`=0, no host access pending and a nonzero setting, is followed by one decide cycle (all three outputs as in scanning). In the cycle after that, `asleep`=1.
- R4: A sleep entered with setting N (1 to 255) ends on the N-th `slowTick`. The launch state (`scanStart`=1) follows in the next cycle, and the block stays asleep through the first N-1 ticks.
- R5: If `anyTouch` is 1 together with `scanDone`, the block launches another scan (`scanStart`=1) two cycles later instead of sleeping. This repeats for each touched pass, and sleep resumes after the first pass with `anyTouch`=0.
- R6: A `hostAct` pulse during sleep ends the sleep in the next cycle with a launch, however many ticks remain.
- R7: A `hostAct` pulse received while the block is awake is held until the next launch. It makes the next decision launch one more scan, and only one more, instead of sleeping.
- R8: With a setting of 0, every decision launches a new scan and the block never sleeps.
- R9: `scanClkEn` is 0 in exactly the cycles in which `asleep` is 1.
- R10: Once awake, the block does not return to sleep until it receives a `scanDone` while scanning. `slowTick` has no effect while the block is awake, and `scanDone` has no effect while it is asleep.
- R11: The setting is captured when sleep is entered. Changing `sleepTicks` during a sleep does not change the length of that sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanDone | input | 1 | One-cycle pulse at the end of a full matrix pass |
| anyTouch | input | 1 | High with scanDone if any key was detected in that pass |
| hostAct | input | 1 | One-cycle strobe for a host bus access |
| sleepTicks | input | 8 | Sleep length in low-rate ticks; 0 disables sleep |
| slowTick | input | 1 | One-cycle pulse from the low-rate divider |
| scanStart | output | 1 | One-cycle pulse that launches a matrix pass |
| asleep | output | 1 | High while the block is in its sleep state |
| scanClkEn | output | 1 | Clock enable for the scan logic; low only in sleep |

## Verification
The bench targets the exact length of a sleep at both ends of the setting range (1 and 255 ticks). An off-by-one in the timer would wake the block one tick early or one tick late. It drives a host strobe while the block is scanning: a design that drops the strobe would sleep straight away, and one that never clears it would scan forever. It changes the setting during a sleep and then sets it to zero, which exposes a timer that samples the live input or a zero setting that stalls the block in sleep. Finally, it sends stray end-of-scan pulses during sleep and stray ticks during scans. A controller that acts on either would sleep without first completing a scan, or would wake early.

// File: rtl/scan_sleep_pkg.sv
package scan_sleep_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP     = 2'd0,
    ST_WAKE_SCAN = 2'd1,
    ST_SCAN      = 2'd2,
    ST_DECIDE    = 2'd3
  } scanState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadTimer;     // capture the sleep setting into the timer
    logic runTimer;      // let slow ticks advance the timer
    logic captureTouch;  // register the touch flag of the finished pass
    logic clearHost;     // consume the pending host request
  } sleepStrobes_t;

endpackage

// File: rtl/scan_sleep_datapath.sv
module scan_sleep_datapath
  import scan_sleep_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sleepStrobes_t     strobes,
  input  logic              anyTouch,
  input  logic              hostAct,
  input  logic [TICK_W-1:0] sleepTicks,
  input  logic              slowTick,
  output logic              timerExpire,
  output logic              touchSeen,
  output logic              hostPending,
  output logic              sleepOff
);

  localparam logic [TICK_W-1:0] TICK_ZERO = '0;
  localparam logic [TICK_W-1:0] TICK_ONE  = TICK_W'(1);

  logic [TICK_W-1:0] tickCount;

  // The setting is sampled only at sleep entry; later changes wait for the next sleep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCount <= TICK_ZERO;
    end else if (strobes.loadTimer) begin
      tickCount <= sleepTicks;
    end else if (strobes.runTimer && slowTick && (tickCount != TICK_ZERO)) begin
      tickCount <= tickCount - TICK_ONE;
    end
  end

  assign timerExpire = strobes.runTimer && slowTick && (tickCount == TICK_ONE);
  assign sleepOff    = (sleepTicks == TICK_ZERO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      touchSeen <= 1'b0;
    end else if (strobes.captureTouch) begin
      touchSeen <= anyTouch;
    end
  end

  // A new strobe wins over the clear, so a request never gets lost
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostPending <= 1'b0;
    end else if (hostAct) begin
      hostPending <= 1'b1;
    end else if (strobes.clearHost) begin
      hostPending <= 1'b0;
    end
  end

  // R4
  timer_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runTimer |-> (tickCount != TICK_ZERO));

  // R7
  host_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAct |=> hostPending);

endmodule

// File: rtl/scan_sleep_fsm.sv
module scan_sleep_fsm
  import scan_sleep_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          scanDone,
  input  logic          hostAct,
  input  logic          timerExpire,
  input  logic          touchSeen,
  input  logic          hostPending,
  input  logic          sleepOff,
  output sleepStrobes_t strobes,
  output logic          scanStart,
  output logic          asleep,
  output logic          scanClkEn
);

  scanState_e state;
  scanState_e nextState;
  logic       keepScanning;

  assign keepScanning = touchSeen || hostPending || hostAct || sleepOff;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_WAKE_SCAN: nextState = ST_SCAN;
      ST_SCAN:      if (scanDone) nextState = ST_DECIDE;
      ST_DECIDE:    nextState = keepScanning ? ST_WAKE_SCAN : ST_SLEEP;
      ST_SLEEP:     if (hostAct || timerExpire) nextState = ST_WAKE_SCAN;
      default:      nextState = ST_WAKE_SCAN;
    endcase
  end

  // Reset lands in the launch state, so the first pass follows power-up
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_WAKE_SCAN;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    strobes.loadTimer    = (state == ST_DECIDE);
    strobes.runTimer     = (state == ST_SLEEP);
    strobes.captureTouch = (state == ST_SCAN) && scanDone;
    strobes.clearHost    = (state == ST_WAKE_SCAN);
  end

  assign scanStart = (state == ST_WAKE_SCAN);
  assign asleep    = (state == ST_SLEEP);
  assign scanClkEn = (state != ST_SLEEP);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |=> !scanStart);

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> ($past(state) == ST_DECIDE));

  // R5
  touch_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && touchSeen) |=> scanStart);

  // R6
  host_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && hostAct) |=> scanStart);

  // R8
  no_sleep_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && sleepOff) |=> !asleep);

endmodule

// File: rtl/scan_sleep_ctrl.sv
module scan_sleep_ctrl
  import scan_sleep_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanDone,
  input  logic              anyTouch,
  input  logic              hostAct,
  input  logic [TICK_W-1:0] sleepTicks,
  input  logic              slowTick,
  output logic              scanStart,
  output logic              asleep,
  output logic              scanClkEn
);

  sleepStrobes_t strobes;
  logic          timerExpire;
  logic          touchSeen;
  logic          hostPending;
  logic          sleepOff;

  scan_sleep_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .scanDone    (scanDone),
    .hostAct     (hostAct),
    .timerExpire (timerExpire),
    .touchSeen   (touchSeen),
    .hostPending (hostPending),
    .sleepOff    (sleepOff),
    .strobes     (strobes),
    .scanStart   (scanStart),
    .asleep      (asleep),
    .scanClkEn   (scanClkEn)
  );

  scan_sleep_datapath #(.TICK_W(TICK_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .anyTouch    (anyTouch),
    .hostAct     (hostAct),
    .sleepTicks  (sleepTicks),
    .slowTick    (slowTick),
    .timerExpire (timerExpire),
    .touchSeen   (touchSeen),
    .hostPending (hostPending),
    .sleepOff    (sleepOff)
  );

  // R9
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> !scanClkEn && !scanStart);

endmodule

// File: tb/scan_sleep_ctrl_test.sv
module scan_sleep_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scanDone = 1'b0;
  logic       anyTouch = 1'b0;
  logic       hostAct = 1'b0;
  logic [7:0] sleepTicks = 8'd3;
  logic       slowTick = 1'b0;
  logic       scanStart;
  logic       asleep;
  logic       scanClkEn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // observed outputs as {scanStart, asleep, scanClkEn}
  logic [2:0] obs;
  localparam logic [2:0] LAUNCH = 3'b101;
  localparam logic [2:0] BUSY   = 3'b001;
  localparam logic [2:0] SLEEPY = 3'b010;

  assign obs = {scanStart, asleep, scanClkEn};

  always #4 clk = ~clk;

  scan_sleep_ctrl uut (
    .clk        (clk),
    .rstN       (rstN),
    .scanDone   (scanDone),
    .anyTouch   (anyTouch),
    .hostAct    (hostAct),
    .sleepTicks (sleepTicks),
    .slowTick   (slowTick),
    .scanStart  (scanStart),
    .asleep     (asleep),
    .scanClkEn  (scanClkEn)
  );

  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s: outputs got %b expected %b at %0t", req, obs, exp, $time);
    end
  endtask

  // Ends a scan; returns at the negedge of the decide cycle
  task automatic endScan(input logic touch);
    scanDone = 1'b1;
    anyTouch = touch;
    @(negedge clk);
    scanDone = 1'b0;
    anyTouch = 1'b0;
  endtask

  task automatic pulseTick();
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic pulseHost();
    hostAct = 1'b1;
    @(negedge clk);
    hostAct = 1'b0;
  endtask

  // Ends in the scanning state
  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", LAUNCH);
    rstN = 1'b1;
    chk("R1 after release", LAUNCH);
    @(negedge clk);
    chk("R1 moves to scan", BUSY);
  endtask

  // From scanning to sleep
  task automatic testIdleSleep();
    pulseTick();
    chk("R10 tick ignored while scanning", BUSY);
    endScan(1'b0);
    chk("R3 decide cycle", BUSY);
    @(negedge clk);
    chk("R3 R9 asleep after idle scan", SLEEPY);
  endtask

  // From sleep (setting 3) to scanning
  task automatic testTimerWake();
    endScan(1'b0);
    chk("R10 scanDone ignored in sleep", SLEEPY);
    pulseTick();
    chk("R4 tick 1 of 3", SLEEPY);
    pulseTick();
    chk("R4 tick 2 of 3", SLEEPY);
    pulseTick();
    chk("R4 wake on tick 3", LAUNCH);
    @(negedge clk);
    chk("R2 start is one cycle", BUSY);
  endtask

  // From scanning to sleep
  task automatic testTouchRepeat();
    endScan(1'b1);
    @(negedge clk);
    chk("R5 touch relaunch", LAUNCH);
    @(negedge clk);
    endScan(1'b1);
    @(negedge clk);
    chk("R5 second touch relaunch", LAUNCH);
    @(negedge clk);
    endScan(1'b0);
    @(negedge clk);
    chk("R5 sleep after release", SLEEPY);
  endtask

  // From sleep to sleep
  task automatic testHostWake();
    pulseTick();
    pulseHost();
    chk("R6 host wakes at once", LAUNCH);
    @(negedge clk);
    chk("R2 scanning after launch", BUSY);
    repeat (5) @(negedge clk);
    chk("R10 stays awake until scan end", BUSY);
    endScan(1'b0);
    @(negedge clk);
    chk("R6 sleeps after one scan", SLEEPY);
  endtask

  // From sleep to sleep
  task automatic testHostDuringScan();
    pulseHost();
    @(negedge clk);
    chk("R7 scanning", BUSY);
    pulseHost();
    repeat (2) @(negedge clk);
    endScan(1'b0);
    @(negedge clk);
    chk("R7 extra scan for host", LAUNCH);
    @(negedge clk);
    endScan(1'b0);
    @(negedge clk);
    chk("R7 only one extra scan", SLEEPY);
  endtask

  // From sleep (setting 3 captured) to scanning with setting 0
  task automatic testSettingChange();
    sleepTicks = 8'd0;
    pulseTick();
    pulseTick();
    chk("R11 live change ignored", SLEEPY);
    pulseTick();
    chk("R11 wakes on captured count", LAUNCH);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      endScan(1'b0);
      @(negedge clk);
      chk("R8 zero setting relaunches", LAUNCH);
      @(negedge clk);
    end
  endtask

  // From scanning to scanning
  task automatic testBoundaries();
    sleepTicks = 8'd1;
    endScan(1'b0);
    @(negedge clk);
    chk("R4 sleep with setting 1", SLEEPY);
    repeat (3) @(negedge clk);
    chk("R4 no wake without tick", SLEEPY);
    pulseTick();
    chk("R4 wake on single tick", LAUNCH);
    @(negedge clk);
    sleepTicks = 8'd255;
    endScan(1'b0);
    @(negedge clk);
    chk("R9 asleep for long sleep", SLEEPY);
    for (int i = 0; i < 254; i++) pulseTick();
    chk("R4 still asleep after 254", SLEEPY);
    pulseTick();
    chk("R4 wake on tick 255", LAUNCH);
    @(negedge clk);
    chk("R2 back to scanning", BUSY);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testIdleSleep();
    testTimerWake();
    testTouchRepeat();
    testHostWake();
    testHostDuringScan();
    testSettingChange();
    testBoundaries();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule